// File: doc/BRIEF.md
# Ethernet Transmit Framer and Serializer

This block turns a stream of frame bytes into the serial bit stream of one Ethernet frame. A start request arrives while the block is idle. On the next bit-clock enable the block begins sending, and it sends one bit for each enable after that. It first sends a 62-bit alternating preamble, then a two-bit synch of two ones. It then takes bytes from a byte-wide ready/valid source and sends each one least significant bit first. After the byte flagged as the last one, it sends a 32-bit frame check sequence.

Each data bit goes to the line and into a serial CRC-32 register during the same enable. The register is preset to all ones when the frame starts, so the preamble and synch never enter it. After the last byte, the complement of the register is shifted out most significant bit first, straight from the register. A transmit-enable output marks the whole frame. If the source has no byte ready when a byte is due, the frame is cut short and an underrun flag is raised.

The block sits between a transmit FIFO and the line coder. It has no internal byte buffer. The source sees `in_ready` in the same clock as the bit enable at each byte boundary, and the byte is taken in that clock.

Top module: `eth_tx_serializer`

## Requirements
- R1: After reset, `tx_en`, `tx_bit`, `underrun` and `in_ready` are all 0.
- R2: A `start` pulse is recorded only while no frame is in progress. The first frame bit appears on the next `bit_en`. A `start` seen during a frame has no effect, so `tx_en` stays 0 after that frame ends.
- R3: Bits 0 to 61 of a frame alternate 1,0,1,0 starting with 1. Bits 62 and 63 are both 1. `tx_en` and `tx_bit` change only on a clock where `bit_en` is 1.
- R4: Each byte is sent least significant bit first, starting at bit 64. A byte is taken in the clock where `bit_en`, `in_ready` and `in_valid` are all 1, and exactly as many bytes are taken as the frame holds. `in_ready` is never high in two clocks in a row.
- R5: The check value is CRC-32 with polynomial 0x04C11DB7. The register is preset to all ones, and only the data bits are fed into it, in the order they are sent.
- R6: Straight after bit 7 of the byte taken with `in_last`=1, 32 FCS bits follow. They are the complemented register, most significant bit first. As a result, FCS bit k equals bit k of the standard reflected CRC-32 of the data bytes.
- R7: `tx_en` is 1 from the first preamble bit through the last FCS bit, which is 96+8n bit times for n bytes. It is then 0 for at least one bit time. `tx_bit` is 0 whenever `tx_en` is 0.
- R8: If `in_valid` is 0 when a byte is due, `tx_en` falls on that enable and no further bits are sent. After a frame of k complete bytes, this leaves 64+8k bits. `underrun` rises in the same clock and stays 1 until the next frame starts.
- R9: A `start` given during the single idle bit time after a frame starts the next frame on the following enable. This makes the gap between frames exactly one bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high clock |
| start | input | 1 | Request to send a frame |
| in_data | input | 8 | Frame byte from the FIFO |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | This byte is the final one of the frame |
| in_ready | output | 1 | Byte is taken this clock when `in_valid` is also 1 |
| tx_bit | output | 1 | Serial line bit |
| tx_en | output | 1 | High for every bit of the frame |
| underrun | output | 1 | Frame was cut short for lack of data |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that `bit_en` is the only thing that moves the output registers, so the output must stay constant over every clock where it is low. The stimulus drives every input on the falling edge of the clock. It makes `bit_en` a one-clock pulse with a low clock after it. It keeps `in_data` and `in_last` constant until a handshake takes the byte, and it ends each underrun case by simply dropping `in_valid`.

// File: rtl/ethtx_pkg.sv
// Package: shared constants and types for the Ethernet transmit serializer.
// Assumes the preamble length is even, so that the synch follows a 0 bit.
package ethtx_pkg;
    localparam int unsigned PRE_BITS  = 62;
    localparam int unsigned SYNC_BITS = 2;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;

    // Frame phase of the sequencer
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_FCS
    } tx_state_e;

    // Which source drives the next line bit
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_HDR,
        SRC_LOAD,
        SRC_SHIFT,
        SRC_FCS
    } bit_src_e;
endpackage

// File: rtl/ethtx_crc_serial.sv
// Module: bit-serial CRC register with a preset input, a feed input for
// data bits and a drain input that shifts the register toward its MSB.
// Assumes that init, feed and drain are never high in the same clock.
module ethtx_crc_serial #(
    parameter int unsigned   W    = 32,
    parameter logic [W-1:0]  POLY = 32'h04C11DB7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic feed_i,
    input  logic din_i,
    input  logic drain_i,
    output logic fcs_bit_o
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_fed;
    logic         fb;

    // Next register value when one data bit is fed in
    always_comb begin
        fb      = crc_q[W-1] ^ din_i;
        crc_fed = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Register update: preset, feed or drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init_i) begin
            crc_q <= '1;
        end else if (feed_i) begin
            crc_q <= crc_fed;
        end else if (drain_i) begin
            crc_q <= {crc_q[W-2:0], 1'b1};
        end
    end

    assign fcs_bit_o = ~crc_q[W-1];

    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (crc_q == '1)); // R5
endmodule

// File: rtl/ethtx_byte_shift.sv
// Module: holds the byte being sent and presents its next bit, LSB first.
// Bit 0 leaves straight from the input on the load clock, so the register
// keeps only the remaining upper bits.
module ethtx_byte_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] data_i,
    output logic         bit_o
);
    logic [W-1:0] sh_q;

    // Load the upper bits of a new byte, or move to the next bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= {1'b0, data_i[W-1:1]};
        end else if (shift_i) begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end

    assign bit_o = sh_q[0];
endmodule

// File: rtl/ethtx_seq.sv
// Module: frame sequencer. It walks the phases idle, header, data and FCS,
// and moves one step on each bit enable. For every step it names the source
// of the line bit and drives the controls of the CRC register and the byte
// shifter. Assumes bit_en is high for one clock per line bit.
module ethtx_seq
    import ethtx_pkg::*;
#(
    parameter int unsigned PRE_N  = 62,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned BYTE_N = 8,
    parameter int unsigned CRC_N  = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en_i,
    input  logic     start_i,
    input  logic     in_valid_i,
    input  logic     in_last_i,
    output logic     in_ready_o,
    output logic     emit_o,
    output bit_src_e src_o,
    output logic     hdr_bit_o,
    output logic     load_o,
    output logic     shift_o,
    output logic     crc_init_o,
    output logic     crc_feed_o,
    output logic     crc_drain_o,
    output logic     frame_start_o,
    output logic     underrun_o
);
    localparam int unsigned HDR_N = PRE_N + SYNC_N;
    localparam int unsigned MAXC  = (HDR_N > CRC_N + 1) ? HDR_N : CRC_N + 1;
    localparam int unsigned CNT_W = $clog2(MAXC) + 1;

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_q, last_d;
    logic             pend_q;

    // Header pattern: alternate from 1 through the preamble, then all ones
    assign hdr_bit_o  = (cnt_q >= CNT_W'(PRE_N)) || !cnt_q[0];
    // Byte boundary in the data phase
    assign in_ready_o = bit_en_i && (state_q == ST_DATA) && (cnt_q == '0);

    // Next-state, bit source and control strobes for this bit enable
    always_comb begin
        state_d       = state_q;
        cnt_d         = cnt_q;
        last_d        = last_q;
        emit_o        = 1'b0;
        src_o         = SRC_NONE;
        load_o        = 1'b0;
        shift_o       = 1'b0;
        crc_init_o    = 1'b0;
        crc_feed_o    = 1'b0;
        crc_drain_o   = 1'b0;
        frame_start_o = 1'b0;
        underrun_o    = 1'b0;
        if (bit_en_i) begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        emit_o        = 1'b1;
                        src_o         = SRC_HDR;
                        crc_init_o    = 1'b1;
                        frame_start_o = 1'b1;
                        state_d       = ST_HDR;
                        cnt_d         = CNT_W'(1);
                    end
                end
                ST_HDR: begin
                    emit_o = 1'b1;
                    src_o  = SRC_HDR;
                    if (cnt_q == CNT_W'(HDR_N - 1)) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == '0) begin
                        if (in_valid_i) begin
                            emit_o     = 1'b1;
                            src_o      = SRC_LOAD;
                            load_o     = 1'b1;
                            crc_feed_o = 1'b1;
                            last_d     = in_last_i;
                            cnt_d      = CNT_W'(1);
                        end else begin
                            underrun_o = 1'b1;
                            state_d    = ST_IDLE;
                        end
                    end else begin
                        emit_o     = 1'b1;
                        src_o      = SRC_SHIFT;
                        shift_o    = 1'b1;
                        crc_feed_o = 1'b1;
                        if (cnt_q == CNT_W'(BYTE_N - 1)) begin
                            cnt_d = '0;
                            if (last_q) begin
                                state_d = ST_FCS;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_FCS: begin
                    if (cnt_q == CNT_W'(CRC_N)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        emit_o      = 1'b1;
                        src_o       = SRC_FCS;
                        crc_drain_o = 1'b1;
                        cnt_d       = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Phase, counter and last-byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    // Start request is recorded only between frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (frame_start_o) begin
            pend_q <= 1'b0;
        end else if (start_i && state_q == ST_IDLE) begin
            pend_q <= 1'b1;
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |=> !in_ready_o); // R4
endmodule

// File: rtl/eth_tx_serializer.sv
// Module: top of the Ethernet transmit serializer. It combines the sequencer,
// the byte shifter and the serial CRC, and registers the line bit and the
// transmit enable on each bit enable. Assumes in_data and in_last stay
// constant while in_valid is high and no byte has been taken.
module eth_tx_serializer
    import ethtx_pkg::*;
#(
    parameter int unsigned DW = ethtx_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          start,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          in_ready,
    output logic          tx_bit,
    output logic          tx_en,
    output logic          underrun
);
    bit_src_e src;
    logic emit, hdr_bit, load, shift, crc_init, crc_feed, crc_drain;
    logic frame_start, underrun_ev, sh_bit, fcs_bit, crc_din, bit_d;
    logic tx_bit_q, tx_en_q, underrun_q;

    ethtx_seq #(
        .PRE_N (PRE_BITS),
        .SYNC_N(SYNC_BITS),
        .BYTE_N(DW),
        .CRC_N (CRC_W)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en_i     (bit_en),
        .start_i      (start),
        .in_valid_i   (in_valid),
        .in_last_i    (in_last),
        .in_ready_o   (in_ready),
        .emit_o       (emit),
        .src_o        (src),
        .hdr_bit_o    (hdr_bit),
        .load_o       (load),
        .shift_o      (shift),
        .crc_init_o   (crc_init),
        .crc_feed_o   (crc_feed),
        .crc_drain_o  (crc_drain),
        .frame_start_o(frame_start),
        .underrun_o   (underrun_ev)
    );

    ethtx_byte_shift #(.W(DW)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .shift_i(shift),
        .data_i (in_data),
        .bit_o  (sh_bit)
    );

    ethtx_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (crc_init),
        .feed_i   (crc_feed),
        .din_i    (crc_din),
        .drain_i  (crc_drain),
        .fcs_bit_o(fcs_bit)
    );

    // Data bit fed to the CRC: a fresh byte's bit 0 or the shifter output
    assign crc_din = (src == SRC_LOAD) ? in_data[0] : sh_bit;

    // Pick the line bit from the named source
    always_comb begin
        case (src)
            SRC_HDR:   bit_d = hdr_bit;
            SRC_LOAD:  bit_d = in_data[0];
            SRC_SHIFT: bit_d = sh_bit;
            SRC_FCS:   bit_d = fcs_bit;
            default:   bit_d = 1'b0;
        endcase
    end

    // Line outputs move only on a bit enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q  <= 1'b0;
            tx_bit_q <= 1'b0;
        end else if (bit_en) begin
            tx_en_q  <= emit;
            tx_bit_q <= emit & bit_d;
        end
    end

    // Underrun flag holds until the next frame starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun_q <= 1'b0;
        end else if (frame_start) begin
            underrun_q <= 1'b0;
        end else if (underrun_ev) begin
            underrun_q <= 1'b1;
        end
    end

    assign tx_en    = tx_en_q;
    assign tx_bit   = tx_bit_q;
    assign underrun = underrun_q;

    AST_BIT_PER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_en_q) && $stable(tx_bit_q))); // R3
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_q |-> !tx_bit_q); // R7
    AST_UNDERRUN_DROPS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_q) |-> $fell(tx_en_q)); // R8
endmodule

// File: tb/test_eth_tx_serializer.sv
`timescale 1ns/1ps
module test_eth_tx_serializer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic in_ready, tx_bit, tx_en, underrun;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] src_bytes [0:63];
    int src_n = 0;
    int src_idx = 0;
    bit src_has_last = 1'b0;
    logic cap [0:2047];
    int cap_n = 0;
    int pre_idle = 0;

    always #2.5 clk = ~clk;

    eth_tx_serializer i_eth_tx_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit), .tx_en(tx_en), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_inputs();
        in_valid = (src_idx < src_n);
        in_data  = (src_idx < src_n) ? src_bytes[src_idx] : 8'h00;
        in_last  = src_has_last && (src_idx == src_n - 1);
    endtask

    // One bit time: enable pulse, handshake, then sample the outputs
    task automatic tick();
        bit hs;
        @(negedge clk);
        bit_en = 1'b1;
        #0.5;
        hs = in_ready && in_valid;
        @(negedge clk);
        bit_en = 1'b0;
        if (hs) begin
            src_idx++;
            set_inputs();
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Collect bits while tx_en is high; mid_start pokes start during the frame
    task automatic capture(input bit mid_start);
        bit seen;
        bit low_ok;
        seen = 1'b0;
        low_ok = 1'b1;
        cap_n = 0;
        pre_idle = 0;
        for (int t = 0; t < 1500; t++) begin
            tick();
            if (tx_en) begin
                cap[cap_n] = tx_bit;
                cap_n++;
                seen = 1'b1;
                if (mid_start && cap_n == 10) pulse_start();
            end else begin
                if (tx_bit) low_ok = 1'b0;
                if (seen) break;
                pre_idle++;
            end
        end
        check(low_ok, "R7 tx_bit low while tx_en low", low_ok, 1);
    endtask

    function automatic logic [31:0] crc_ref(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, src_bytes[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Compare the captured stream against header, k data bytes and, if fcs, the FCS
    task automatic check_stream(input int k, input bit fcs);
        int exp_len, bad;
        logic [31:0] c;
        exp_len = 64 + 8 * k + (fcs ? 32 : 0);
        check(cap_n == exp_len, fcs ? "R7 frame length" : "R8 cut frame length", cap_n, exp_len);
        bad = 0;
        for (int i = 0; i < 64; i++)
            if (cap[i] !== ((i >= 62) || (i % 2 == 0))) bad++;
        check(bad == 0, "R3 preamble and synch", bad, 0);
        bad = 0;
        for (int i = 0; i < 8 * k; i++)
            if (64 + i < cap_n && cap[64 + i] !== src_bytes[i / 8][i % 8]) bad++;
        check(bad == 0, "R4 data LSB first", bad, 0);
        if (fcs) begin
            c = crc_ref(k);
            bad = 0;
            for (int i = 0; i < 32; i++)
                if (64 + 8 * k + i < cap_n && cap[64 + 8 * k + i] !== c[i]) bad++;
            check(bad == 0, "R5 R6 FCS bits", bad, 0);
        end
        check(src_idx == k, "R4 bytes taken", src_idx, k);
    endtask

    task automatic load_frame(input int n, input int seed, input bit has_last);
        for (int i = 0; i < n; i++) src_bytes[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        src_n = n;
        src_idx = 0;
        src_has_last = has_last;
        set_inputs();
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en == 0 && tx_bit == 0 && underrun == 0, "R1 reset outputs",
              {tx_en, tx_bit, underrun}, 0);
        bit_en = 1'b1; #0.5;
        check(in_ready == 0, "R1 in_ready idle", in_ready, 0);
        @(negedge clk); bit_en = 1'b0;

        // No start: the line stays idle
        for (int i = 0; i < 3; i++) tick();
        check(tx_en == 0, "R2 idle without start", tx_en, 0);

        // Bench model sanity on a known check value
        for (int i = 0; i < 9; i++) src_bytes[i] = 8'(8'h31 + i);
        check(crc_ref(9) == 32'hCBF43926, "R5 reference CRC", crc_ref(9), 32'hCBF43926);

        // Known string frame
        src_n = 9; src_idx = 0; src_has_last = 1'b1; set_inputs();
        pulse_start();
        capture(1'b0);
        check(pre_idle == 0, "R2 first bit on next enable", pre_idle, 0);
        check_stream(9, 1'b1);

        // Sweep frame lengths and patterns
        for (int n = 1; n <= 24; n++) begin
            load_frame(n, n, 1'b1);
            pulse_start();
            capture(1'b0);
            check_stream(n, 1'b1);
        end

        // Constant fills
        for (int i = 0; i < 4; i++) src_bytes[i] = 8'h00;
        src_n = 4; src_idx = 0; src_has_last = 1'b1; set_inputs();
        pulse_start(); capture(1'b0); check_stream(4, 1'b1);
        for (int i = 0; i < 4; i++) src_bytes[i] = 8'hFF;
        src_n = 4; src_idx = 0; src_has_last = 1'b1; set_inputs();
        pulse_start(); capture(1'b0); check_stream(4, 1'b1);

        // Start during a frame is ignored
        load_frame(6, 3, 1'b1);
        pulse_start();
        capture(1'b1);
        check_stream(6, 1'b1);
        for (int i = 0; i < 5; i++) tick();
        check(tx_en == 0, "R2 start while busy ignored", tx_en, 0);

        // Back to back: start during the single idle bit time
        load_frame(5, 7, 1'b1);
        pulse_start();
        capture(1'b0);
        check_stream(5, 1'b1);
        load_frame(3, 9, 1'b1);
        pulse_start();
        capture(1'b0);
        check(pre_idle == 0, "R9 one bit gap", pre_idle, 0);
        check_stream(3, 1'b1);

        // Underrun after k bytes
        for (int k = 0; k < 4; k++) begin
            load_frame(k, k + 20, 1'b0);
            pulse_start();
            capture(1'b0);
            check_stream(k, 1'b0);
            check(underrun == 1, "R8 underrun flag set", underrun, 1);
            for (int i = 0; i < 3; i++) tick();
            check(underrun == 1 && tx_en == 0, "R8 flag held, line idle", {underrun, tx_en}, 2);
        end
        load_frame(2, 40, 1'b1);
        pulse_start();
        capture(1'b0);
        check_stream(2, 1'b1);
        check(underrun == 0, "R8 flag cleared by new frame", underrun, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule